// File: doc/BRIEF.md
# I2C Bus Hang Timeout Counter

This block watches a serial bus controller for a stall while software waits for its next event. When the enable bit is set and the serial event flag is clear, a free-running counter advances once per core clock. Any valid bus activity clears it. If the count runs past its top value, the counter wraps and a sticky timeout flag is raised.

The block also holds the serial event flag. The protocol engine sets that flag, and software clears it. A single interrupt request is the OR of the event flag and the timeout flag. Neither flag is ever cleared by hardware. The counter width is a parameter and defaults to 14 bits, so a timeout fires after 16384 idle counting cycles.

Top module: `i2c_hang_timer`

## Requirements
- R1: After reset the event flag, the timeout flag, the interrupt output and the internal count are all zero.
- R2: The count advances by one on each clock edge where `tmo_en_i` is 1, the event flag is 0, `evt_set_i` is 0 and `bus_act_i` is 0.
- R3: The timeout flag sets on the 2^CNT_W-th consecutive counting edge (16384 at the default width).
- R4: While the event flag is set, or is being set, the count is held at zero, so no timeout can occur.
- R5: With `tmo_en_i` at 0 the count is zero after the next edge. After re-enabling, a timeout needs a full 2^CNT_W counting edges.
- R6: A `bus_act_i` pulse on an edge clears the count. A timeout then needs 2^CNT_W further counting edges.
- R7: On overflow the count wraps to zero and counting goes on. A later overflow comes 2^CNT_W edges after the previous one, and the timeout flag stays set throughout.
- R8: Each flag is cleared only by its own strobe (`evt_clr_i`, `tmo_clr_i`). If a set and a clear fall on the same edge, the set wins.
- R9: `irq_o` is 1 exactly when the event flag or the timeout flag is 1.
- R10: A clear strobe that arrives while its flag is already 0 has no effect on the count or on the timeout timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmo_en_i | input | 1 | Timeout counting enable |
| evt_set_i | input | 1 | Protocol engine raises the serial event flag |
| evt_clr_i | input | 1 | Software clear strobe for the event flag |
| bus_act_i | input | 1 | Valid bus activity pulse |
| tmo_clr_i | input | 1 | Software clear strobe for the timeout flag |
| evt_flag_o | output | 1 | Serial event flag |
| tmo_flag_o | output | 1 | Timeout flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses a 5-bit counter and checks the exact overflow edge, one cycle before it and on it. It does this for a bus-activity pulse placed at every count position, so a restart that is off by one or a missed clear shifts the edge and is reported. It checks that the overflow period repeats after a flag clear, which would break if the counter saturated instead of wrapping. It also holds the event flag for several periods to catch counting that is not gated, and it drives a set and a clear on the same edge to catch wrong priority. Finally, it sends idle clear strobes mid-count to catch a design that wrongly restarts the counter on them.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
  typedef enum logic {
    OP_CLEAR = 1'b0,
    OP_STEP  = 1'b1
  } cnt_op_e;
endpackage

// File: rtl/i2c_tmo_sticky.sv
module i2c_tmo_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  assert_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o && !set_i) |=> !q_o);
endmodule

// File: rtl/i2c_tmo_counter.sv
module i2c_tmo_counter
  import i2c_tmo_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // wraps to zero naturally at the top value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (op_i == OP_CLEAR) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
  assign ovf_o = (op_i == OP_STEP) && (cnt_q == CntMax);

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLEAR) |=> (cnt_o == '0));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_STEP) && !ovf_o) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_o == '0));
endmodule

// File: rtl/i2c_hang_timer.sv
module i2c_hang_timer
  import i2c_tmo_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmo_en_i,
  input  logic evt_set_i,
  input  logic evt_clr_i,
  input  logic bus_act_i,
  input  logic tmo_clr_i,
  output logic evt_flag_o,
  output logic tmo_flag_o,
  output logic irq_o
);
  logic             evt_q;
  logic             tmo_q;
  logic             ovf;
  logic [CNT_W-1:0] cnt;
  cnt_op_e          op;

  // count only while enabled, event flag clear and bus quiet
  always_comb begin
    op = OP_STEP;
    if (!tmo_en_i || evt_q || evt_set_i || bus_act_i) op = OP_CLEAR;
  end

  i2c_tmo_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .cnt_o (cnt),
    .ovf_o (ovf)
  );

  i2c_tmo_sticky u_evt_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_set_i),
    .clr_i (evt_clr_i),
    .q_o   (evt_q)
  );

  i2c_tmo_sticky u_tmo_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ovf),
    .clr_i (tmo_clr_i),
    .q_o   (tmo_q)
  );

  assign evt_flag_o = evt_q;
  assign tmo_flag_o = tmo_q;
  assign irq_o      = evt_q | tmo_q;

  assert_hold_on_event_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (cnt == '0 && !ovf));
  assert_ovf_sets_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> tmo_flag_o);
  assert_activity_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act_i |=> (cnt == '0));
  assert_irq_on_timeout_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_flag_o) |-> irq_o);
endmodule

// File: tb/i2c_hang_timer_bench.sv
module i2c_hang_timer_bench;
  localparam int W   = 5;
  localparam int LIM = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, evt_set = 1'b0, evt_clr = 1'b0, act = 1'b0, tmo_clr = 1'b0;
  logic evt_o, tmo_o, irq_o;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  i2c_hang_timer #(.CNT_W(W)) u_i2c_hang_timer (
    .clk_i(clk), .rst_ni(rst_n), .tmo_en_i(en), .evt_set_i(evt_set),
    .evt_clr_i(evt_clr), .bus_act_i(act), .tmo_clr_i(tmo_clr),
    .evt_flag_o(evt_o), .tmo_flag_o(tmo_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic act_v, input logic exp_v, input string what);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act_v, exp_v, $time);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // timeout must appear on exactly the n-th edge from now
  task automatic expect_ovf(input int n, input string req);
    cyc(n - 1);
    chk(req, tmo_o, 1'b0, "timeout one edge early");
    cyc(1);
    chk(req, tmo_o, 1'b1, "timeout on its edge");
    chk("R9", irq_o, 1'b1, "irq with timeout");
  endtask

  // disable for one edge and clear timeout flag
  task automatic restart();
    en = 1'b0; tmo_clr = 1'b1;
    cyc(1);
    en = 1'b1; tmo_clr = 1'b0;
    chk("R8", tmo_o, 1'b0, "timeout cleared by strobe");
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", evt_o, 1'b0, "event flag after reset");
    chk("R1", tmo_o, 1'b0, "timeout flag after reset");
    chk("R1", irq_o, 1'b0, "irq after reset");

    // R2 R3: first timeout from reset
    en = 1'b1;
    expect_ovf(LIM, "R3");

    // R7: flag remains set across further wraps
    for (int i = 0; i < 3 * LIM; i++) begin
      cyc(1);
      chk("R7", tmo_o, 1'b1, "timeout stays set");
    end
    // clear, next overflow one period after previous one
    tmo_clr = 1'b1;
    cyc(1);
    tmo_clr = 1'b0;
    chk("R8", tmo_o, 1'b0, "timeout cleared");
    chk("R9", irq_o, 1'b0, "irq after clear");
    expect_ovf(LIM - 1, "R7");

    // R6: activity pulse at every count position
    for (int p = 1; p < LIM; p++) begin
      restart();
      cyc(p);
      act = 1'b1;
      cyc(1);
      act = 1'b0;
      expect_ovf(LIM, "R6");
    end

    // R4: event flag blocks counting
    restart();
    cyc(7);
    evt_set = 1'b1;
    cyc(1);
    evt_set = 1'b0;
    chk("R4", evt_o, 1'b1, "event flag set");
    chk("R9", irq_o, 1'b1, "irq from event");
    cyc(3 * LIM);
    chk("R4", tmo_o, 1'b0, "no timeout while event set");
    chk("R8", evt_o, 1'b1, "event flag sticky");
    evt_clr = 1'b1;
    cyc(1);
    evt_clr = 1'b0;
    chk("R8", evt_o, 1'b0, "event flag cleared");
    chk("R9", irq_o, 1'b0, "irq idle");
    expect_ovf(LIM, "R4");

    // R8: set beats clear for event flag
    restart();
    evt_set = 1'b1; evt_clr = 1'b1;
    cyc(1);
    evt_set = 1'b0;
    chk("R8", evt_o, 1'b1, "event set wins");
    cyc(1);
    evt_clr = 1'b0;
    chk("R8", evt_o, 1'b0, "event clear");

    // R8: set beats clear for timeout flag
    restart();
    cyc(LIM - 1);
    tmo_clr = 1'b1;
    cyc(1);
    tmo_clr = 1'b0;
    chk("R8", tmo_o, 1'b1, "timeout set wins");

    // R5: disable mid count, and long disable
    restart();
    cyc(20);
    en = 1'b0;
    cyc(1);
    en = 1'b1;
    expect_ovf(LIM, "R5");
    restart();
    en = 1'b0;
    cyc(3 * LIM);
    chk("R5", tmo_o, 1'b0, "no timeout while disabled");
    en = 1'b1;
    expect_ovf(LIM, "R5");

    // R10: idle clear strobes leave the count alone
    restart();
    cyc(10);
    evt_clr = 1'b1; tmo_clr = 1'b1;
    cyc(1);
    evt_clr = 1'b0; tmo_clr = 1'b0;
    chk("R10", irq_o, 1'b0, "irq after idle strobes");
    expect_ovf(LIM - 11, "R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule